// File: doc/BRIEF.md
# Enhanced Memory Region Permission Checker

This block decides, in one combinational pass, whether a single memory access may proceed. It takes the access address, the access length in bytes, the requested read/write/execute bits and a flag that says whether the requester runs in machine mode. It also takes a bank of per-region configuration bytes with their address registers, and two security switches. It returns an allow flag, a hit flag and the index of the region that decided the outcome. Writing the configuration, raising traps and logging are left to the surrounding logic.

Each region has an address mode: off, top-of-range, one aligned word, or a naturally aligned power-of-two span. Regions are searched from index 0 upward, and the lowest-indexed region that fully contains the access alone decides the result. When the lockdown switch is set, the region lock bit changes meaning. A locked region becomes a machine-only region and an unlocked one becomes a user-only region. The write-only permission encoding is reused to mark code or data regions that both sides share. A second switch, strict-machine, removes the default permission that machine-mode accesses otherwise have when they match no region.

Top module: `pmpx_access_check`

## Requirements
- R1: Each configuration byte holds read in bit 0, write in bit 1, execute in bit 2, the address mode in bits 4:3 (0 off, 1 top-of-range, 2 aligned word, 3 power-of-two span) and the lock in bit 7. A region matches only when both the first and the last byte of the access lie inside it and its mode is not off. An access whose last byte wraps past the top of the address space matches no region. A size of 0 is treated as one byte.
- R2: In top-of-range mode, address registers hold the byte address shifted right by 2. The region covers byte addresses from the previous region's register times 4 (zero for region 0), inclusive, up to its own register times 4, exclusive.
- R3: Aligned-word mode covers the four bytes at register times 4. Power-of-two mode with k trailing ones in the register covers 2^(k+3) bytes, aligned to that size, that contain register times 4. A register of all ones covers the whole space.
- R4: When several regions match, the lowest index decides. The hit output shows that a region matched and hit_idx gives its index. hit_idx is 0 when nothing matches.
- R5: When every region is off: deny if strict-machine is set; otherwise deny if lockdown is set and the access is non-machine or requests execute; otherwise allow.
- R6: When some region is active but none matches: a non-machine access is denied. A machine access is allowed unless strict-machine is set, or lockdown is set and execute is requested.
- R7: With lockdown clear, a matching unlocked region grants all three permissions to machine mode. In every other case the region grants its own R/W/X bits.
- R8: With lockdown set, a locked region with write set and read clear is shared code. It grants execute to all modes, and also grants read to machine mode when its execute bit is set.
- R9: With lockdown set, any other locked region grants its R/W/X bits. A non-machine access that hits it is denied whenever those bits are non-zero.
- R10: With lockdown set, an unlocked region with write set and read clear is shared data. It grants read to all modes, and also grants write when the access is machine-mode or its execute bit is set.
- R11: With lockdown set, any other unlocked region grants its R/W/X bits. A machine access that hits it is denied whenever those bits are non-zero.
- R12: The request vector carries read in bit 0, write in bit 1 and execute in bit 2. A matched access is allowed only if every requested bit is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_addr | input | PADDR_W | Byte address of the first byte accessed |
| acc_size | input | SIZE_W | Access length in bytes |
| acc_req | input | 3 | Requested permissions {execute, write, read} |
| acc_mach | input | 1 | 1 when the requester runs in machine mode |
| region_cfg | input | N_REGIONS*8 | Configuration byte of each region, region 0 in the low byte |
| region_addr | input | N_REGIONS*(PADDR_W-2) | Address register of each region, region 0 in the low field |
| lockdown_en | input | 1 | Switches the lock bit to the machine-only/user-only meaning |
| strict_m_en | input | 1 | Denies machine accesses that match no region |
| allow | output | 1 | 1 when the access may proceed |
| hit | output | 1 | 1 when some region matched |
| hit_idx | output | IDX_W | Index of the deciding region, 0 when none |

## Verification
The assertions watch relations that must hold for every input combination. They check that the selected region is one-hot and is itself a matching region. They check that strict-machine and unmatched execute under lockdown never end in allow. They check that non-machine grants stay within the region bits when lockdown is clear, and that machine-only and user-only regions veto the wrong side. Which region wins when regions overlap, the exact top-of-range and power-of-two boundaries, the wrap past the top of the address space and the shared-region grants can only be shown by the bench. It compares full outcomes against its own model, both in directed corner cases and in many random configurations.

// File: rtl/pmpx_pkg.sv
package pmpx_pkg;

   typedef enum logic [1:0] {
      AM_OFF   = 2'd0,
      AM_TOR   = 2'd1,
      AM_NA4   = 2'd2,
      AM_NAPOT = 2'd3
   } amode_e;

   // Configuration byte: bit 7 lock, 6:5 unused, 4:3 mode, 2 X, 1 W, 0 R
   typedef struct packed {
      logic       lock;
      logic [1:0] rsvd;
      amode_e     amode;
      logic       x;
      logic       w;
      logic       r;
   } rcfg_t;

   localparam int PERM_R = 0;
   localparam int PERM_W = 1;
   localparam int PERM_X = 2;

endpackage

// File: rtl/pmpx_region_match.sv
module pmpx_region_match #(
   parameter int PADDR_W = 32,
   localparam int WA_W = PADDR_W - 2
) (
   input  logic [PADDR_W-1:0] first_b,
   input  logic [PADDR_W-1:0] last_b,
   input  logic               end_wrap,
   input  pmpx_pkg::amode_e   amode,
   input  logic [WA_W-1:0]    lo_word,
   input  logic [WA_W-1:0]    own_word,
   output logic               matched
);
   import pmpx_pkg::*;

   logic [WA_W-1:0] first_w, last_w, span_mask;
   logic            in_tor, in_na4, in_napot;

   assign first_w   = first_b[PADDR_W-1:2];
   assign last_w    = last_b[PADDR_W-1:2];
   // trailing ones plus the first zero above them
   assign span_mask = own_word ^ (own_word + 1'b1);

   assign in_tor   = (first_w >= lo_word) && (first_w < own_word) &&
                     (last_w  >= lo_word) && (last_w  < own_word);
   assign in_na4   = (first_w == own_word) && (last_w == own_word);
   assign in_napot = ((first_w & ~span_mask) == (own_word & ~span_mask)) &&
                     ((last_w  & ~span_mask) == (own_word & ~span_mask));

   always_comb begin
      unique case (amode)
         AM_TOR:   matched = in_tor;
         AM_NA4:   matched = in_na4;
         AM_NAPOT: matched = in_napot;
         default:  matched = 1'b0;
      endcase
      if (end_wrap) matched = 1'b0;
   end

endmodule

// File: rtl/pmpx_prio_pick.sv
module pmpx_prio_pick #(
   parameter int N = 8,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     hits,
   output logic [N-1:0]     sel_oh,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   assign sel_oh = hits & (~hits + 1'b1);
   assign any    = |hits;

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hits[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/pmpx_perm_eval.sv
module pmpx_perm_eval (
   input  pmpx_pkg::rcfg_t cfg,
   input  logic            mach,
   input  logic            lockdown,
   input  logic [2:0]      req,
   output logic            granted
);
   import pmpx_pkg::*;

   logic [2:0] own_bits, allowed;
   logic       shared, veto;

   assign own_bits = {cfg.x, cfg.w, cfg.r};
   assign shared   = cfg.w && !cfg.r;

   always_comb begin
      veto    = 1'b0;
      allowed = own_bits;
      if (!lockdown) begin
         if (mach && !cfg.lock) allowed = 3'b111;
      end else if (cfg.lock) begin
         if (shared) begin
            allowed = 3'b000;
            allowed[PERM_X] = 1'b1;
            allowed[PERM_R] = mach && cfg.x;
         end else begin
            veto = !mach && (own_bits != 3'b000);
         end
      end else begin
         if (shared) begin
            allowed = 3'b000;
            allowed[PERM_R] = 1'b1;
            allowed[PERM_W] = mach || cfg.x;
         end else begin
            veto = mach && (own_bits != 3'b000);
         end
      end
   end

   assign granted = !veto && ((req & ~allowed) == 3'b000);

   always_comb begin
      // p_m_only_r9: locked private regions refuse the non-machine side
      assert (!(lockdown && cfg.lock && !shared && !mach &&
                own_bits != 3'b000) || !granted)
         else $error("p_m_only_r9");
      // p_u_only_r11: unlocked private regions refuse the machine side
      assert (!(lockdown && !cfg.lock && !shared && mach &&
                own_bits != 3'b000) || !granted)
         else $error("p_u_only_r11");
   end

endmodule

// File: rtl/pmpx_access_check.sv
module pmpx_access_check #(
   parameter int N_REGIONS = 8,
   parameter int PADDR_W   = 32,
   parameter int SIZE_W    = 4,
   localparam int IDX_W    = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1
) (
   input  logic [PADDR_W-1:0]               acc_addr,
   input  logic [SIZE_W-1:0]                acc_size,
   input  logic [2:0]                       acc_req,
   input  logic                             acc_mach,
   input  logic [N_REGIONS*8-1:0]           region_cfg,
   input  logic [N_REGIONS*(PADDR_W-2)-1:0] region_addr,
   input  logic                             lockdown_en,
   input  logic                             strict_m_en,
   output logic                             allow,
   output logic                             hit,
   output logic [IDX_W-1:0]                 hit_idx
);
   import pmpx_pkg::*;

   localparam int WA_W = PADDR_W - 2;

   if (N_REGIONS < 1 || N_REGIONS > 64) begin : g_bad_count
      $error("N_REGIONS must lie in 1..64");
   end
   if (PADDR_W < 8) begin : g_bad_addr
      $error("PADDR_W must be at least 8");
   end
   if (SIZE_W < 1 || SIZE_W >= PADDR_W) begin : g_bad_size
      $error("SIZE_W must lie in 1..PADDR_W-1");
   end

   logic [SIZE_W-1:0]    span;
   logic [PADDR_W:0]     end_ext;
   logic [PADDR_W-1:0]   last_b;
   logic                 end_wrap;

   assign span     = (acc_size == '0) ? '0 : acc_size - 1'b1;
   assign end_ext  = {1'b0, acc_addr} + {{(PADDR_W + 1 - SIZE_W){1'b0}}, span};
   assign last_b   = end_ext[PADDR_W-1:0];
   assign end_wrap = end_ext[PADDR_W];

   rcfg_t                cfg_a [N_REGIONS];
   logic [N_REGIONS-1:0] hits, live, sel_oh;

   for (genvar r = 0; r < N_REGIONS; r++) begin : g_region
      logic [WA_W-1:0] lo_w;
      assign cfg_a[r] = rcfg_t'(region_cfg[r*8 +: 8]);
      assign live[r]  = (cfg_a[r].amode != AM_OFF);
      if (r == 0) begin : g_base
         assign lo_w = '0;
      end else begin : g_prev
         assign lo_w = region_addr[(r-1)*WA_W +: WA_W];
      end
      pmpx_region_match #(.PADDR_W(PADDR_W)) u_match (
         .first_b  (acc_addr),
         .last_b   (last_b),
         .end_wrap (end_wrap),
         .amode    (cfg_a[r].amode),
         .lo_word  (lo_w),
         .own_word (region_addr[r*WA_W +: WA_W]),
         .matched  (hits[r])
      );
   end

   pmpx_prio_pick #(.N(N_REGIONS)) u_pick (
      .hits   (hits),
      .sel_oh (sel_oh),
      .any    (hit),
      .idx    (hit_idx)
   );

   rcfg_t sel_cfg;
   always_comb begin
      sel_cfg = '0;
      for (int r = 0; r < N_REGIONS; r++) begin
         if (sel_oh[r]) sel_cfg = rcfg_t'(sel_cfg | cfg_a[r]);
      end
   end

   logic region_ok, rules_on, miss_ok;

   pmpx_perm_eval u_eval (
      .cfg      (sel_cfg),
      .mach     (acc_mach),
      .lockdown (lockdown_en),
      .req      (acc_req),
      .granted  (region_ok)
   );

   assign rules_on = |live;

   always_comb begin
      if (strict_m_en) begin
         miss_ok = 1'b0;
      end else if (lockdown_en && (!acc_mach || acc_req[PERM_X])) begin
         miss_ok = 1'b0;
      end else begin
         miss_ok = acc_mach || !rules_on;
      end
   end

   assign allow = hit ? region_ok : miss_ok;

   always_comb begin
      // p_onehot_sel_r4
      assert ($onehot0(sel_oh)) else $error("p_onehot_sel_r4");
      // p_idx_is_hit_r4
      assert (!hit || hits[hit_idx]) else $error("p_idx_is_hit_r4");
      // p_strict_miss_r6
      assert (!(strict_m_en && !hit) || !allow) else $error("p_strict_miss_r6");
      // p_exec_miss_r5
      assert (!(lockdown_en && !hit && acc_req[PERM_X]) || !allow)
         else $error("p_exec_miss_r5");
      // p_user_bound_r7
      assert (!(allow && hit && !lockdown_en && !acc_mach) ||
              ((acc_req & ~{sel_cfg.x, sel_cfg.w, sel_cfg.r}) == 3'b000))
         else $error("p_user_bound_r7");
   end

endmodule

// File: tb/pmpx_access_check_tb_top.sv
module pmpx_access_check_tb_top;

   localparam int NR = 8;
   localparam int AW = 32;
   localparam int WW = AW - 2;
   localparam int SW = 4;

   logic            clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic [AW-1:0]    acc_addr;
   logic [SW-1:0]    acc_size;
   logic [2:0]       acc_req;
   logic             acc_mach;
   logic [NR*8-1:0]  region_cfg;
   logic [NR*WW-1:0] region_addr;
   logic             lockdown_en, strict_m_en;
   logic             allow, hit;
   logic [2:0]       hit_idx;

   pmpx_access_check #(.N_REGIONS(NR), .PADDR_W(AW), .SIZE_W(SW)) dut_i (
      .acc_addr    (acc_addr),
      .acc_size    (acc_size),
      .acc_req     (acc_req),
      .acc_mach    (acc_mach),
      .region_cfg  (region_cfg),
      .region_addr (region_addr),
      .lockdown_en (lockdown_en),
      .strict_m_en (strict_m_en),
      .allow       (allow),
      .hit         (hit),
      .hit_idx     (hit_idx)
   );

   logic [7:0]    cfg_m  [NR];
   logic [WW-1:0] areg_m [NR];
   int n_checks = 0;
   int n_errors = 0;
   bit done = 0;

   function automatic bit in_region(int r, longint unsigned w);
      longint unsigned lo, hi, own;
      int t;
      own = longint'(areg_m[r]);
      case (cfg_m[r][4:3])
         2'd1: begin
            lo = (r == 0) ? 0 : longint'(areg_m[r-1]);
            return (w >= lo) && (w < own);
         end
         2'd2: return w == own;
         2'd3: begin
            t = 0;
            while (t < WW && own[t]) t++;
            if (t >= WW) return 1'b1;
            lo = (own >> (t + 1)) << (t + 1);
            hi = lo + (longint'(1) << (t + 1));
            return (w >= lo) && (w < hi);
         end
         default: return 1'b0;
      endcase
   endfunction

   task automatic ref_eval(output bit e_allow, output bit e_hit,
                           output int e_idx, output string tag);
      longint unsigned fb, lb;
      bit any_live;
      bit [2:0] own, alw;
      bit veto, shared, lk;
      fb = longint'(acc_addr);
      lb = fb + ((acc_size == 0) ? 0 : longint'(acc_size) - 1);
      e_hit = 0; e_idx = 0; any_live = 0;
      for (int r = 0; r < NR; r++) begin
         if (cfg_m[r][4:3] != 2'd0) any_live = 1;
         if (!e_hit && lb <= 64'hFFFF_FFFF && cfg_m[r][4:3] != 2'd0 &&
             in_region(r, fb >> 2) && in_region(r, lb >> 2)) begin
            e_hit = 1; e_idx = r;
         end
      end
      if (!e_hit) begin
         if (!any_live) begin
            tag = "R5";
            e_allow = !strict_m_en && !(lockdown_en && (!acc_mach || acc_req[2]));
         end else begin
            tag = "R6";
            e_allow = acc_mach && !strict_m_en && !(lockdown_en && acc_req[2]);
         end
         return;
      end
      own = cfg_m[e_idx][2:0];
      lk = cfg_m[e_idx][7];
      shared = own[1] && !own[0];
      veto = 0; alw = own;
      if (!lockdown_en) begin
         tag = "R7";
         if (acc_mach && !lk) alw = 3'b111;
      end else if (lk && shared) begin
         tag = "R8";
         alw = {1'b1, 1'b0, acc_mach && own[2]};
      end else if (lk) begin
         tag = "R9";
         veto = !acc_mach && own != 0;
      end else if (shared) begin
         tag = "R10";
         alw = {1'b0, acc_mach || own[2], 1'b1};
      end else begin
         tag = "R11";
         veto = acc_mach && own != 0;
      end
      e_allow = !veto && ((acc_req & ~alw) == 0);
   endtask

   task automatic run_vec(input string dtag);
      bit e_allow, e_hit;
      int e_idx;
      string tag;
      @(posedge clk);
      for (int r = 0; r < NR; r++) begin
         region_cfg[r*8 +: 8]    = cfg_m[r];
         region_addr[r*WW +: WW] = areg_m[r];
      end
      @(negedge clk);
      ref_eval(e_allow, e_hit, e_idx, tag);
      if (dtag != "") tag = dtag;
      n_checks++;
      if (allow !== e_allow) begin
         n_errors++;
         $display("FAIL %s allow: actual %0b expected %0b", tag, allow, e_allow);
      end
      n_checks++;
      if (hit !== e_hit || int'(hit_idx) != e_idx) begin
         n_errors++;
         $display("FAIL %s hit/idx: actual %0b/%0d expected %0b/%0d",
                  tag, hit, hit_idx, e_hit, e_idx);
      end
   endtask

   task automatic clear_regions();
      for (int r = 0; r < NR; r++) begin
         cfg_m[r] = 8'h00; areg_m[r] = '0;
      end
   endtask

   task automatic set_acc(input logic [AW-1:0] a, input logic [SW-1:0] s,
                          input logic [2:0] q, input logic m,
                          input logic ld, input logic st);
      acc_addr = a; acc_size = s; acc_req = q; acc_mach = m;
      lockdown_en = ld; strict_m_en = st;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_errors++; n_checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      int seed;
      logic [3:0] sizes [4];
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      sizes[0] = 4'd1; sizes[1] = 4'd2; sizes[2] = 4'd4; sizes[3] = 4'd8;
      region_cfg = '0; region_addr = '0;

      // R5: reset-like state, all regions off
      clear_regions();
      set_acc(32'h100, 4'd4, 3'b001, 1'b0, 1'b0, 1'b0); run_vec("R5");
      set_acc(32'h100, 4'd4, 3'b001, 1'b0, 1'b1, 1'b0); run_vec("R5");
      set_acc(32'h100, 4'd4, 3'b100, 1'b1, 1'b1, 1'b0); run_vec("R5");
      set_acc(32'h100, 4'd4, 3'b011, 1'b1, 1'b1, 1'b0); run_vec("R5");
      set_acc(32'h100, 4'd4, 3'b001, 1'b1, 1'b0, 1'b1); run_vec("R5");

      // R1: straddling an aligned word, and wrap past the top
      clear_regions();
      cfg_m[0] = 8'h17; areg_m[0] = 30'd4;          // NA4 rwx at bytes 16..19
      set_acc(32'd18, 4'd4, 3'b001, 1'b0, 1'b0, 1'b0); run_vec("R1");
      set_acc(32'd16, 4'd4, 3'b001, 1'b0, 1'b0, 1'b0); run_vec("R1");
      set_acc(32'd16, 4'd0, 3'b001, 1'b0, 1'b0, 1'b0); run_vec("R1");
      clear_regions();
      cfg_m[0] = 8'h1F; areg_m[0] = '1;              // NAPOT whole space
      set_acc(32'hFFFF_FFFE, 4'd4, 3'b001, 1'b1, 1'b0, 1'b0); run_vec("R1");
      set_acc(32'hFFFF_FFFC, 4'd4, 3'b001, 1'b0, 1'b0, 1'b0); run_vec("R3");

      // R2: top-of-range boundaries, bytes 16..31 through region 1
      clear_regions();
      areg_m[0] = 30'd4; cfg_m[1] = 8'h0B; areg_m[1] = 30'd8;
      set_acc(32'd28, 4'd4, 3'b011, 1'b0, 1'b0, 1'b0); run_vec("R2");
      set_acc(32'd30, 4'd4, 3'b001, 1'b0, 1'b0, 1'b0); run_vec("R2");
      set_acc(32'd15, 4'd2, 3'b001, 1'b0, 1'b0, 1'b0); run_vec("R2");
      set_acc(32'd16, 4'd1, 3'b001, 1'b0, 1'b0, 1'b0); run_vec("R2");

      // R3: power-of-two span of 32 bytes at 64
      clear_regions();
      cfg_m[0] = 8'h19; areg_m[0] = 30'b10011;
      set_acc(32'd92, 4'd4, 3'b001, 1'b0, 1'b0, 1'b0); run_vec("R3");
      set_acc(32'd96, 4'd4, 3'b001, 1'b0, 1'b0, 1'b0); run_vec("R3");
      set_acc(32'd62, 4'd4, 3'b001, 1'b0, 1'b0, 1'b0); run_vec("R3");

      // R4: overlap, lowest index wins
      clear_regions();
      cfg_m[2] = 8'h11; areg_m[2] = 30'd20;          // NA4 read only
      cfg_m[5] = 8'h1F; areg_m[5] = 30'b10111;       // NAPOT rwx covering it
      set_acc(32'd80, 4'd4, 3'b010, 1'b0, 1'b0, 1'b0); run_vec("R4");
      set_acc(32'd84, 4'd4, 3'b010, 1'b0, 1'b0, 1'b0); run_vec("R4");

      // R12 and R7
      clear_regions();
      cfg_m[0] = 8'h11; areg_m[0] = 30'd1;
      set_acc(32'd4, 4'd4, 3'b011, 1'b0, 1'b0, 1'b0); run_vec("R12");
      set_acc(32'd4, 4'd4, 3'b111, 1'b1, 1'b0, 1'b0); run_vec("R7");
      cfg_m[0] = 8'h91;
      set_acc(32'd4, 4'd4, 3'b010, 1'b1, 1'b0, 1'b0); run_vec("R7");

      // R8..R11 under lockdown
      cfg_m[0] = 8'h96;                               // locked, W+X shared code
      set_acc(32'd4, 4'd4, 3'b001, 1'b1, 1'b1, 1'b0); run_vec("R8");
      set_acc(32'd4, 4'd4, 3'b001, 1'b0, 1'b1, 1'b0); run_vec("R8");
      set_acc(32'd4, 4'd4, 3'b100, 1'b0, 1'b1, 1'b0); run_vec("R8");
      cfg_m[0] = 8'h93;                               // locked R+W
      set_acc(32'd4, 4'd4, 3'b001, 1'b0, 1'b1, 1'b0); run_vec("R9");
      set_acc(32'd4, 4'd4, 3'b011, 1'b1, 1'b1, 1'b0); run_vec("R9");
      cfg_m[0] = 8'h12;                               // unlocked shared data
      set_acc(32'd4, 4'd4, 3'b010, 1'b0, 1'b1, 1'b0); run_vec("R10");
      set_acc(32'd4, 4'd4, 3'b010, 1'b1, 1'b1, 1'b0); run_vec("R10");
      cfg_m[0] = 8'h15;                               // unlocked R+X
      set_acc(32'd4, 4'd4, 3'b001, 1'b1, 1'b1, 1'b0); run_vec("R11");
      set_acc(32'd4, 4'd4, 3'b100, 1'b0, 1'b1, 1'b0); run_vec("R11");

      // R6: rules present, no match
      set_acc(32'd400, 4'd4, 3'b001, 1'b1, 1'b0, 1'b0); run_vec("R6");
      set_acc(32'd400, 4'd4, 3'b001, 1'b1, 1'b0, 1'b1); run_vec("R6");
      set_acc(32'd400, 4'd4, 3'b100, 1'b1, 1'b1, 1'b0); run_vec("R6");
      set_acc(32'd400, 4'd4, 3'b001, 1'b0, 1'b0, 1'b0); run_vec("R6");

      // random mix
      for (int k = 0; k < 4000; k++) begin
         bit all_off;
         all_off = ($urandom % 8) == 0;
         for (int r = 0; r < NR; r++) begin
            cfg_m[r] = 8'($urandom);
            if (all_off) cfg_m[r][4:3] = 2'd0;
            areg_m[r] = WW'($urandom % 256);
         end
         set_acc(AW'($urandom % 1024), sizes[$urandom % 4], 3'($urandom),
                 1'($urandom), 1'($urandom), (($urandom % 4) == 0));
         run_vec("");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule